// File: doc/BRIEF.md
# Bus Borrowing Requester

This controller sits beside a local transfer engine that occasionally needs a shared processor bus it does not normally own. When the engine asks to start, the controller raises a bus request and waits for the arbiter's grant. A grant alone is not enough to take the bus. The controller also waits until the previous owner has stopped addressing (address strobe idle) and the previous slave has finished its cycle (every asynchronous and synchronous termination input idle). It also needs no other device to be holding the grant-acknowledge line. Only when all of these hold does it drive its own acknowledge and take the bus.

While the acknowledge is held, the engine runs its transfers. The request is withdrawn one clock after the acknowledge appears. When the engine reports done, the acknowledge drops, which gives the bus back, and the controller returns to idle after a single release clock. All bus-side inputs are positive-logic and pass through a multi-flop synchronizer before the state machine uses them. The engine's start and done signals are local to the clock domain.

The states are ST_IDLE, ST_REQUEST, ST_WAIT_QUIET, ST_OWN and ST_RELEASE. The transitions are:
- ST_IDLE to ST_REQUEST on start_i.
- ST_REQUEST to ST_WAIT_QUIET when the synchronized grant is high.
- ST_WAIT_QUIET back to ST_REQUEST if the grant goes away.
- ST_WAIT_QUIET to ST_OWN when the grant is high and the bus is quiet.
- ST_OWN to ST_RELEASE on done_i.
- ST_RELEASE to ST_IDLE unconditionally.

Top module: `busborrow_ctrl`

## Requirements
- R1: While rst_n is low and after its release, bus_req_o, bus_ack_o, bus_owned_o and busy_o are all 0 until a start is accepted.
- R2: A start_i pulse seen in ST_IDLE raises bus_req_o and busy_o after the next rising edge. A start_i seen in any other state is ignored and does not cause a second request after the current one ends.
- R3: Every bus-side input (grant, address strobe, each termination line, other acknowledge) passes through SYNC_STAGES flops. With the default of 2, an input that changes before rising edge k affects the state machine at edge k+2, so outputs react after edge k+2.
- R4: bus_ack_o rises only from ST_WAIT_QUIET when, in synchronized form, the grant is 1 and all of the following are 0: the address strobe, every bit of term_async_i, term_sync_i and ack_other_i. Any single one of these at its blocking level holds bus_ack_o at 0.
- R5: bus_req_o stays 1 from ST_REQUEST until one clock after bus_ack_o has risen; it is never withdrawn before the acknowledge is asserted.
- R6: If the synchronized grant falls while in ST_WAIT_QUIET, the controller returns to ST_REQUEST with bus_req_o still 1 and bus_ack_o 0, and claims the bus once the grant returns and the bus is quiet.
- R7: In ST_OWN, bus_ack_o and bus_owned_o stay 1 until done_i is seen. A done_i outside ST_OWN is ignored.
- R8: After done_i in ST_OWN, the next clock is ST_RELEASE with bus_ack_o 0 and busy_o 1. The clock after that is ST_IDLE with busy_o 0.
- R9: busy_o is 1 in every state except ST_IDLE, and bus_ack_o is never 1 while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Engine asks to borrow the bus (pulse) |
| done_i | input | 1 | Engine finished all its bus cycles (pulse) |
| busy_o | output | 1 | Controller is not idle |
| bus_owned_o | output | 1 | Engine may issue transfers |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_grant_i | input | 1 | Grant from the arbiter |
| bus_ack_o | output | 1 | Own grant-acknowledge; high means this device is master |
| ack_other_i | input | 1 | Grant-acknowledge driven by any other device |
| addr_strobe_i | input | 1 | Observed address strobe of the current master |
| term_async_i | input | NUM_TERM | Observed asynchronous cycle-termination lines |
| term_sync_i | input | 1 | Observed synchronous cycle-termination line |

## Verification
On every cycle, the assertions check the ordering rules:
- The acknowledge only rises after a synchronized grant with a quiet bus.
- The request only falls after the acknowledge.
- The acknowledge only falls after done, and is followed by exactly one release clock.
- Busy rises only on a start.

What the assertions cannot show is that each individual blocking input, and each termination bit, really holds the claim off. Nor can they show the exact two-flop latency from an input's release to the acknowledge, the return to request when the grant is withdrawn, or that stray start and done pulses leave no trace. The bench's scenarios show these against its reference model.

// File: rtl/busborrow_pkg.sv
package busborrow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_REQUEST    = 3'd1,
        ST_WAIT_QUIET = 3'd2,
        ST_OWN        = 3'd3,
        ST_RELEASE    = 3'd4
    } bb_state_t;

    localparam int unsigned BB_SYNC_STAGES_DEF = 2;
    localparam int unsigned BB_NUM_TERM_DEF    = 2;

endpackage

// File: rtl/busborrow_sync.sv
module busborrow_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/busborrow_quiet.sv
module busborrow_quiet #(
    parameter int unsigned NUM_TERM = 2
) (
    input  logic                addr_strobe_s,
    input  logic [NUM_TERM-1:0] term_async_s,
    input  logic                term_sync_s,
    input  logic                ack_other_s,
    output logic                quiet_o
);

    logic master_idle;
    logic slave_idle;
    logic ack_free;

    // previous master no longer addressing
    assign master_idle = ~addr_strobe_s;
    // previous slave has terminated on every path
    assign slave_idle  = ~(|term_async_s) & ~term_sync_s;
    // nobody else holds the acknowledge line
    assign ack_free    = ~ack_other_s;

    assign quiet_o = master_idle & slave_idle & ack_free;

endmodule

// File: rtl/busborrow_fsm.sv
module busborrow_fsm
    import busborrow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    input  logic grant_s,
    input  logic quiet_s,
    output logic bus_req_o,
    output logic bus_ack_o,
    output logic bus_owned_o,
    output logic busy_o
);

    bb_state_t state_q, state_d;
    logic      first_own_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_REQUEST;
            ST_REQUEST:    if (grant_s) state_d = ST_WAIT_QUIET;
            ST_WAIT_QUIET: begin
                if (!grant_s)     state_d = ST_REQUEST;
                else if (quiet_s) state_d = ST_OWN;
            end
            ST_OWN:        if (done_i) state_d = ST_RELEASE;
            ST_RELEASE:    state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            first_own_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            first_own_q <= (state_d == ST_OWN) && (state_q != ST_OWN);
        end
    end

    always_comb begin
        bus_req_o   = 1'b0;
        bus_ack_o   = 1'b0;
        bus_owned_o = 1'b0;
        busy_o      = 1'b1;
        unique case (state_q)
            ST_IDLE:       busy_o = 1'b0;
            ST_REQUEST:    bus_req_o = 1'b1;
            ST_WAIT_QUIET: bus_req_o = 1'b1;
            ST_OWN: begin
                bus_ack_o   = 1'b1;
                bus_owned_o = 1'b1;
                bus_req_o   = first_own_q;
            end
            ST_RELEASE:    bus_ack_o = 1'b0;
            default:       busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/busborrow_ctrl.sv
module busborrow_ctrl
    import busborrow_pkg::*;
#(
    parameter int unsigned NUM_TERM    = BB_NUM_TERM_DEF,
    parameter int unsigned SYNC_STAGES = BB_SYNC_STAGES_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                done_i,
    output logic                busy_o,
    output logic                bus_owned_o,
    output logic                bus_req_o,
    input  logic                bus_grant_i,
    output logic                bus_ack_o,
    input  logic                ack_other_i,
    input  logic                addr_strobe_i,
    input  logic [NUM_TERM-1:0] term_async_i,
    input  logic                term_sync_i
);

    localparam int unsigned SW = NUM_TERM + 4;

    logic [SW-1:0]       raw_in;
    logic [SW-1:0]       syn_in;
    logic                grant_s;
    logic                strobe_s;
    logic [NUM_TERM-1:0] term_async_s;
    logic                term_sync_s;
    logic                other_s;
    logic                quiet_s;

    assign raw_in = {ack_other_i, term_sync_i, term_async_i, addr_strobe_i, bus_grant_i};

    busborrow_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    assign grant_s      = syn_in[0];
    assign strobe_s     = syn_in[1];
    assign term_async_s = syn_in[NUM_TERM+1:2];
    assign term_sync_s  = syn_in[NUM_TERM+2];
    assign other_s      = syn_in[NUM_TERM+3];

    busborrow_quiet #(.NUM_TERM(NUM_TERM)) quiet_i (
        .addr_strobe_s (strobe_s),
        .term_async_s  (term_async_s),
        .term_sync_s   (term_sync_s),
        .ack_other_s   (other_s),
        .quiet_o       (quiet_s)
    );

    busborrow_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .done_i      (done_i),
        .grant_s     (grant_s),
        .quiet_s     (quiet_s),
        .bus_req_o   (bus_req_o),
        .bus_ack_o   (bus_ack_o),
        .bus_owned_o (bus_owned_o),
        .busy_o      (busy_o)
    );

endmodule

// File: rtl/busborrow_chk.sv
module busborrow_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic done_i,
    input logic busy_o,
    input logic bus_req_o,
    input logic bus_ack_o,
    input logic grant_s,
    input logic quiet_s
);

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R2

    AST_ACK_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack_o) |-> $past(grant_s && quiet_s)); // R4

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack_o) |-> $past(bus_req_o)); // R5

    AST_REQ_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req_o) |-> $past(bus_ack_o)); // R5

    AST_NO_CLAIM_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_s && !bus_ack_o) |=> !bus_ack_o); // R6

    AST_ACK_DROP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_o) |-> ($past(done_i) && busy_o)); // R7

    AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_o) |=> !busy_o); // R8

    AST_ACK_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_o |-> busy_o); // R9

endmodule

bind busborrow_ctrl busborrow_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .done_i    (done_i),
    .busy_o    (busy_o),
    .bus_req_o (bus_req_o),
    .bus_ack_o (bus_ack_o),
    .grant_s   (grant_s),
    .quiet_s   (quiet_s)
);

// File: tb/busborrow_ctrl_tb_top.sv
`timescale 1ns/1ps
module busborrow_ctrl_tb_top;

    localparam int NT = 2;
    localparam int SYNC = 2;
    localparam int W = NT + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          done_i = 1'b0;
    logic          bus_grant_i = 1'b0;
    logic          ack_other_i = 1'b0;
    logic          addr_strobe_i = 1'b0;
    logic [NT-1:0] term_async_i = '0;
    logic          term_sync_i = 1'b0;
    logic          busy_o, bus_owned_o, bus_req_o, bus_ack_o;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    busborrow_ctrl #(.NUM_TERM(NT), .SYNC_STAGES(SYNC)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .done_i        (done_i),
        .busy_o        (busy_o),
        .bus_owned_o   (bus_owned_o),
        .bus_req_o     (bus_req_o),
        .bus_grant_i   (bus_grant_i),
        .bus_ack_o     (bus_ack_o),
        .ack_other_i   (ack_other_i),
        .addr_strobe_i (addr_strobe_i),
        .term_async_i  (term_async_i),
        .term_sync_i   (term_sync_i)
    );

    // ---------------- reference model ----------------
    // mode: 0 idle, 1 asking, 2 granted-waiting, 3 owner, 4 giving back
    int         m_mode = 0;
    bit         m_fresh = 0;
    logic [W-1:0] hist[$];

    function automatic bit m_req();  return (m_mode == 1) || (m_mode == 2) || (m_mode == 3 && m_fresh); endfunction
    function automatic bit m_ack();  return m_mode == 3; endfunction
    function automatic bit m_busy(); return m_mode != 0; endfunction

    always @(posedge clk) begin
        logic [W-1:0] seen;
        bit g, calm;
        int nxt;
        if (!rst_n) begin
            m_mode = 0;
            m_fresh = 0;
            hist.delete();
            for (int i = 0; i < SYNC; i++) hist.push_front('0);
        end else begin
            seen = hist[$];
            void'(hist.pop_back());
            hist.push_front({ack_other_i, term_sync_i, term_async_i, addr_strobe_i, bus_grant_i});
            g    = seen[0];
            calm = (seen[W-1:1] == '0);
            nxt  = m_mode;
            case (m_mode)
                0: if (start_i) nxt = 1;
                1: if (g) nxt = 2;
                2: if (!g) nxt = 1; else if (calm) nxt = 3;
                3: if (done_i) nxt = 4;
                default: nxt = 0;
            endcase
            m_fresh = (nxt == 3) && (m_mode != 3);
            m_mode  = nxt;
        end
        #2;
        vectors++;
        if (bus_req_o !== m_req() || bus_ack_o !== m_ack() || bus_owned_o !== m_ack() || busy_o !== m_busy()) begin
            miscompares++;
            $display("FAIL %s t=%0t req/ack/own/busy actual %b%b%b%b expected %b%b%b%b", cur_req, $time,
                     bus_req_o, bus_ack_o, bus_owned_o, busy_o, m_req(), m_ack(), m_ack(), m_busy());
        end
    end

    // ---------------- directed expectations ----------------
    task automatic tick(); @(negedge clk); endtask

    task automatic expect_out(input bit req, input bit ack, input bit busy, input string tag);
        vectors++;
        if (bus_req_o !== req || bus_ack_o !== ack || busy_o !== busy) begin
            miscompares++;
            $display("FAIL %s t=%0t req/ack/busy actual %b%b%b expected %b%b%b", tag, $time,
                     bus_req_o, bus_ack_o, busy_o, req, ack, busy);
        end
    endtask

    task automatic set_block(input int k, input bit v);
        case (k)
            0: addr_strobe_i   = v;
            1: term_async_i[0] = v;
            2: term_async_i[NT-1] = v;
            3: term_sync_i     = v;
            default: ack_other_i = v;
        endcase
    endtask

    task automatic finish_own();
        cur_req = "R7";
        done_i = 1'b1; bus_grant_i = 1'b0;
        tick(); done_i = 1'b0;
        expect_out(1'b0, 1'b0, 1'b1, "R8");
        tick();
        expect_out(1'b0, 1'b0, 1'b0, "R8");
    endtask

    task automatic blocked_claim(input int k);
        cur_req = "R4";
        set_block(k, 1'b1);
        start_i = 1'b1; tick(); start_i = 1'b0;
        bus_grant_i = 1'b1;
        repeat (8) tick();
        expect_out(1'b1, 1'b0, 1'b1, "R4");
        set_block(k, 1'b0);
        cur_req = "R3";
        tick(); tick();
        expect_out(1'b1, 1'b0, 1'b1, "R3");
        tick();
        expect_out(1'b1, 1'b1, 1'b1, "R4");
        tick();
        expect_out(1'b0, 1'b1, 1'b1, "R5");
        finish_own();
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) tick();
        expect_out(1'b0, 1'b0, 1'b0, "R1");
        rst_n = 1'b1;
        repeat (2) tick();
        expect_out(1'b0, 1'b0, 1'b0, "R1");

        // plain borrow, bus already quiet
        cur_req = "R2";
        start_i = 1'b1; tick(); start_i = 1'b0;
        expect_out(1'b1, 1'b0, 1'b1, "R2");
        bus_grant_i = 1'b1;
        cur_req = "R3";
        tick(); tick(); tick();
        expect_out(1'b1, 1'b0, 1'b1, "R3");
        tick();
        expect_out(1'b1, 1'b1, 1'b1, "R4");
        tick();
        cur_req = "R5";
        expect_out(1'b0, 1'b1, 1'b1, "R5");
        repeat (4) tick();
        expect_out(1'b0, 1'b1, 1'b1, "R7");
        finish_own();

        // each blocking condition on its own
        for (int k = 0; k < 5; k++) begin
            tick();
            blocked_claim(k);
        end

        // grant withdrawn while waiting for a quiet bus
        cur_req = "R6";
        addr_strobe_i = 1'b1;
        start_i = 1'b1; tick(); start_i = 1'b0;
        bus_grant_i = 1'b1;
        repeat (6) tick();
        bus_grant_i = 1'b0;
        repeat (4) tick();
        expect_out(1'b1, 1'b0, 1'b1, "R6");
        bus_grant_i = 1'b1; addr_strobe_i = 1'b0;
        repeat (6) tick();
        expect_out(1'b0, 1'b1, 1'b1, "R6");
        finish_own();

        // stray done while asking, stray start while owning
        cur_req = "R7";
        tick();
        start_i = 1'b1; tick(); start_i = 1'b0;
        done_i = 1'b1; tick(); done_i = 1'b0;
        expect_out(1'b1, 1'b0, 1'b1, "R7");
        bus_grant_i = 1'b1;
        repeat (8) tick();
        expect_out(1'b0, 1'b1, 1'b1, "R7");
        cur_req = "R2";
        start_i = 1'b1; tick(); start_i = 1'b0;
        tick();
        expect_out(1'b0, 1'b1, 1'b1, "R2");
        finish_own();
        cur_req = "R9";
        repeat (4) tick();
        expect_out(1'b0, 1'b0, 1'b0, "R2");

        tick();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired, run did not complete");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule